// File: doc/BRIEF.md
# Real-Time Clock with Alarms and Countdown Timer

This block keeps wall-clock time without a calendar. A clock enable at 32.768 kHz feeds a prescaler. The prescaler issues one tick per second, and each tick advances a chain of counters for seconds, minutes, hours and days. The day count is 15 bits wide and wraps to zero, then keeps running.

Two alarms compare against the time:
- One alarm checks only hours, minutes and seconds, so it fires once every day.
- The other alarm also checks the day number.

A countdown timer is decremented once per tick and flags the tick at which it underflows.

Every event sets a sticky status bit. There are seven events: second, minute, hour, day, both alarms and the countdown. Software clears a status bit by writing a one to it. A per-event enable decides whether the event raises the level interrupt and the one-cycle wake pulse.

Software reaches the block through a small register port with a combinational read path. A write to the time register does not change the time at once. It restarts the prescaler, and the new value is loaded on the tick that follows.

Top module: `rtc_core`

## Requirements
- R1: A one-second tick occurs on the clock edge where `tick32k` is high for the PRESCALE-th time since reset, since the previous tick, or since a time write. Cycles with `tick32k` low do not advance the prescaler.
- R2: On each tick:
  - seconds count 0 to 59;
  - minutes advance when seconds wrap from 59 to 0, and count 0 to 59;
  - hours advance when minutes wrap, and count 0 to 23.
- R3: The day counter advances when 23:59:59 rolls over. It wraps from 32767 to 0 and continues counting.
- R4: A write to the time register leaves the readable time unchanged until the next tick. On that tick the written value is loaded as it is, without being incremented. The write also restarts the prescaler count from zero.
- R5: Alarm A keeps only its hour, minute and second fields and reads back with day 0. It sets status bit 4 on a tick whose new time matches those three fields, whatever the day.
- R6: Alarm B sets status bit 5 only when day, hour, minute and second all match the new time.
- R7: Writing the countdown register loads and arms the counter.
  - Each tick decrements it while it is nonzero.
  - The first tick that finds it at zero sets status bit 6 and disarms it.
  - The counter never wraps, and the event does not repeat without a new write.
- R8: Every tick sets status bit 0. A minute rollover also sets bit 1, an hour rollover bit 2 and a day rollover bit 3. A tick that loads a written time sets only bit 0 among these four.
- R9: Status bits are sticky. Writing the status register clears exactly the bits written as 1 and leaves the others unchanged.
- R10: `irq` is high while any status bit is set whose enable bit is set. `wake` is high for exactly the one cycle after a tick that produced an enabled event.
- R11: Register addresses:

  | Address | Register |
  |---|---|
  | 0 | time |
  | 1 | alarm A |
  | 2 | alarm B |
  | 3 | countdown |
  | 4 | interrupt enable |
  | 5 | status |

  Time and alarm words put seconds in bits 5:0, minutes in 11:6, hours in 16:12 and day in 31:17. The countdown occupies the low 16 bits. All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick32k | input | 1 | 32.768 kHz clock enable, one cycle wide per period |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt: any enabled status bit set |
| wake | output | 1 | One-cycle pulse after an enabled event |

## Verification
The hardest state to reach is one where several counters roll over on the same tick, such as a day change or the 15-bit day wrap. Stepping through full days is out of reach for any short run. The bench therefore uses the deferred time load: it writes a time one or two seconds before the boundary, spends one tick on the load, and then steps across the boundary. The bench also overrides the prescaler to four enables per second. This lets it place a time write in the middle of a partial second and show that the prescaler restarts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HOUR_W   = 5;
  localparam int SEC_LSB  = 0;
  localparam int MIN_LSB  = 6;
  localparam int HOUR_LSB = 12;
  localparam int DAY_LSB  = 17;

  localparam int NUM_EVT = 7;
  localparam int EV_SEC  = 0;
  localparam int EV_MIN  = 1;
  localparam int EV_HOUR = 2;
  localparam int EV_DAY  = 3;
  localparam int EV_AL1  = 4;
  localparam int EV_AL2  = 5;
  localparam int EV_SW   = 6;

  localparam logic [2:0] A_TIME = 3'd0;
  localparam logic [2:0] A_AL1  = 3'd1;
  localparam logic [2:0] A_AL2  = 3'd2;
  localparam logic [2:0] A_SW   = 3'd3;
  localparam logic [2:0] A_MASK = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic secTick;
    logic applyStaged;
    logic stageTime;
    logic setAl1;
    logic setAl2;
    logic loadSw;
    logic stepSw;
  } dpCmdT;

  // conditions reported back by the datapath
  typedef struct packed {
    logic rollMin;
    logic rollHour;
    logic rollDay;
    logic hitAl1;
    logic hitAl2;
    logic swZero;
  } dpFlagT;
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int DAY_W  = 15,
  parameter int SW_W   = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmdT             cmd,
  input  logic [DATA_W-1:0] wrData,
  output dpFlagT            flags,
  output logic [DATA_W-1:0] timeWord,
  output logic [DATA_W-1:0] al1Word,
  output logic [DATA_W-1:0] al2Word,
  output logic [DATA_W-1:0] swWord
);
  localparam logic [SEC_W-1:0]  SEC_MAX  = SEC_W'(59);
  localparam logic [MIN_W-1:0]  MIN_MAX  = MIN_W'(59);
  localparam logic [HOUR_W-1:0] HOUR_MAX = HOUR_W'(23);

  logic [SEC_W-1:0]  sec, stgSec, al1Sec, al2Sec, incSec, newSec;
  logic [MIN_W-1:0]  min, stgMin, al1Min, al2Min, incMin, newMin;
  logic [HOUR_W-1:0] hour, stgHour, al1Hour, al2Hour, incHour, newHour;
  logic [DAY_W-1:0]  day, stgDay, al2Day, incDay, newDay;
  logic [SW_W-1:0]   swCount;
  logic secWrap, minWrap, hourWrap;

  // increment chain
  always_comb begin
    secWrap  = (sec == SEC_MAX);
    minWrap  = secWrap && (min == MIN_MAX);
    hourWrap = minWrap && (hour == HOUR_MAX);
    incSec   = secWrap ? '0 : sec + SEC_W'(1);
    incMin   = minWrap ? '0 : (secWrap ? min + MIN_W'(1) : min);
    incHour  = hourWrap ? '0 : (minWrap ? hour + HOUR_W'(1) : hour);
    incDay   = hourWrap ? day + DAY_W'(1) : day;
    newSec   = cmd.applyStaged ? stgSec  : incSec;
    newMin   = cmd.applyStaged ? stgMin  : incMin;
    newHour  = cmd.applyStaged ? stgHour : incHour;
    newDay   = cmd.applyStaged ? stgDay  : incDay;
  end

  always_comb begin
    flags.rollMin  = secWrap  && !cmd.applyStaged;
    flags.rollHour = minWrap  && !cmd.applyStaged;
    flags.rollDay  = hourWrap && !cmd.applyStaged;
    flags.hitAl1   = (newSec == al1Sec) && (newMin == al1Min) && (newHour == al1Hour);
    flags.hitAl2   = (newSec == al2Sec) && (newMin == al2Min) && (newHour == al2Hour)
                     && (newDay == al2Day);
    flags.swZero   = (swCount == '0);
  end

  // time counters and staged write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec <= '0; min <= '0; hour <= '0; day <= '0;
      stgSec <= '0; stgMin <= '0; stgHour <= '0; stgDay <= '0;
    end else begin
      if (cmd.stageTime) begin
        stgSec  <= wrData[SEC_LSB +: SEC_W];
        stgMin  <= wrData[MIN_LSB +: MIN_W];
        stgHour <= wrData[HOUR_LSB +: HOUR_W];
        stgDay  <= wrData[DAY_LSB +: DAY_W];
      end
      if (cmd.secTick) begin
        sec <= newSec; min <= newMin; hour <= newHour; day <= newDay;
      end
    end
  end

  // alarm registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      al1Sec <= '0; al1Min <= '0; al1Hour <= '0;
      al2Sec <= '0; al2Min <= '0; al2Hour <= '0; al2Day <= '0;
    end else begin
      if (cmd.setAl1) begin
        al1Sec  <= wrData[SEC_LSB +: SEC_W];
        al1Min  <= wrData[MIN_LSB +: MIN_W];
        al1Hour <= wrData[HOUR_LSB +: HOUR_W];
      end
      if (cmd.setAl2) begin
        al2Sec  <= wrData[SEC_LSB +: SEC_W];
        al2Min  <= wrData[MIN_LSB +: MIN_W];
        al2Hour <= wrData[HOUR_LSB +: HOUR_W];
        al2Day  <= wrData[DAY_LSB +: DAY_W];
      end
    end
  end

  // countdown value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            swCount <= '0;
    else if (cmd.loadSw)  swCount <= wrData[SW_W-1:0];
    else if (cmd.stepSw)  swCount <= swCount - SW_W'(1);
  end

  always_comb begin
    timeWord = '0;
    timeWord[SEC_LSB +: SEC_W]   = sec;
    timeWord[MIN_LSB +: MIN_W]   = min;
    timeWord[HOUR_LSB +: HOUR_W] = hour;
    timeWord[DAY_LSB +: DAY_W]   = day;
    al1Word = '0;
    al1Word[SEC_LSB +: SEC_W]    = al1Sec;
    al1Word[MIN_LSB +: MIN_W]    = al1Min;
    al1Word[HOUR_LSB +: HOUR_W]  = al1Hour;
    al2Word = '0;
    al2Word[SEC_LSB +: SEC_W]    = al2Sec;
    al2Word[MIN_LSB +: MIN_W]    = al2Min;
    al2Word[HOUR_LSB +: HOUR_W]  = al2Hour;
    al2Word[DAY_LSB +: DAY_W]    = al2Day;
    swWord = DATA_W'(swCount);
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick32k,
  input  logic               wrEn,
  input  logic [2:0]         addr,
  input  logic [NUM_EVT-1:0] ctrlData,
  input  dpFlagT             flags,
  output dpCmdT              cmd,
  output logic [NUM_EVT-1:0] maskReg,
  output logic [NUM_EVT-1:0] statReg,
  output logic               wake
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]    psCnt;
  logic               pending, swArmed, timeWr, secTick, swFire;
  logic [NUM_EVT-1:0] evt, clrVec;

  assign timeWr  = wrEn && (addr == A_TIME);
  assign secTick = tick32k && !timeWr && (psCnt == PS_LAST);

  // prescaler, restarted by a time write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         psCnt <= '0;
    else if (timeWr)   psCnt <= '0;
    else if (tick32k)  psCnt <= (psCnt == PS_LAST) ? '0 : psCnt + PS_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        pending <= 1'b0;
    else if (timeWr)  pending <= 1'b1;
    else if (secTick) pending <= 1'b0;
  end

  always_comb begin
    cmd.secTick     = secTick;
    cmd.applyStaged = pending;
    cmd.stageTime   = timeWr;
    cmd.setAl1      = wrEn && (addr == A_AL1);
    cmd.setAl2      = wrEn && (addr == A_AL2);
    cmd.loadSw      = wrEn && (addr == A_SW);
    cmd.stepSw      = secTick && swArmed && !flags.swZero && !cmd.loadSw;
  end

  assign swFire = secTick && swArmed && flags.swZero && !cmd.loadSw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           swArmed <= 1'b0;
    else if (cmd.loadSw) swArmed <= 1'b1;
    else if (swFire)     swArmed <= 1'b0;
  end

  always_comb begin
    evt          = '0;
    evt[EV_SEC]  = secTick;
    evt[EV_MIN]  = secTick && flags.rollMin;
    evt[EV_HOUR] = secTick && flags.rollHour;
    evt[EV_DAY]  = secTick && flags.rollDay;
    evt[EV_AL1]  = secTick && flags.hitAl1;
    evt[EV_AL2]  = secTick && flags.hitAl2;
    evt[EV_SW]   = swFire;
    clrVec       = (wrEn && (addr == A_STAT)) ? ctrlData : '0;
  end

  // sticky status, one flop per event
  for (genvar i = 0; i < NUM_EVT; i++) begin : gStat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        statReg[i] <= 1'b0;
      else if (evt[i])  statReg[i] <= 1'b1;
      else if (clrVec[i]) statReg[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      wake    <= 1'b0;
    end else begin
      if (wrEn && (addr == A_MASK)) maskReg <= ctrlData;
      wake <= |(evt & maskReg);
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int DAY_W    = 15,
  parameter int SW_W     = 16,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick32k,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wake
);
  dpCmdT              cmd;
  dpFlagT             flags;
  logic [NUM_EVT-1:0] maskReg, statReg;
  logic [DATA_W-1:0]  timeWord, al1Word, al2Word, swWord;
  logic               secTick;

  assign secTick = cmd.secTick;

  rtc_ctrl #(.PRESCALE(PRESCALE)) uCtrl (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn), .addr(addr),
    .ctrlData(wrData[NUM_EVT-1:0]), .flags(flags), .cmd(cmd),
    .maskReg(maskReg), .statReg(statReg), .wake(wake)
  );

  rtc_datapath #(.DAY_W(DAY_W), .SW_W(SW_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData), .flags(flags),
    .timeWord(timeWord), .al1Word(al1Word), .al2Word(al2Word), .swWord(swWord)
  );

  always_comb begin
    case (addr)
      A_TIME:  rdData = timeWord;
      A_AL1:   rdData = al1Word;
      A_AL2:   rdData = al2Word;
      A_SW:    rdData = swWord;
      A_MASK:  rdData = DATA_W'(maskReg);
      A_STAT:  rdData = DATA_W'(statReg);
      default: rdData = '0;
    endcase
  end

  assign irq = |(statReg & maskReg);
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick32k,
  input logic               wrEn,
  input logic [2:0]         addr,
  input logic [NUM_EVT-1:0] wrLow,
  input logic               wake,
  input logic               secTick,
  input logic [DATA_W-1:0]  timeWord,
  input logic [DATA_W-1:0]  swWord,
  input logic [NUM_EVT-1:0] statReg
);
  logic               seenClk;
  logic [NUM_EVT-1:0] clrVec;
  logic               swWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenClk <= 1'b0;
    else       seenClk <= 1'b1;
  end

  assign clrVec = (wrEn && (addr == A_STAT)) ? wrLow : '0;
  assign swWr   = wrEn && (addr == A_SW);

  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> tick32k); // R1

  AST_TIME_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (seenClk && !$past(secTick)) |-> $stable(timeWord)); // R4

  AST_COUNTDOWN_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (seenClk && $past(secTick) && ($past(swWord) == '0) && !$past(swWr)) |-> (swWord == '0)); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    seenClk |-> ((($past(statReg) & ~$past(clrVec)) & ~statReg) == '0)); // R9

  AST_WAKE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (seenClk && wake) |-> $past(secTick)); // R10
endmodule

bind rtc_core rtc_core_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn), .addr(addr),
  .wrLow(wrData[rtc_pkg::NUM_EVT-1:0]), .wake(wake), .secTick(secTick),
  .timeWord(timeWord), .swWord(swWord), .statReg(statReg)
);

// File: tb/rtc_core_test.sv
module rtc_core_test;
  import rtc_pkg::*;
  localparam int PS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick32k = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq, wake;
  int          total = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rtc_core #(.PRESCALE(PS)) uut (
    .clk(clk), .rstN(rstN), .tick32k(tick32k), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wake(wake)
  );

  function automatic logic [31:0] pk(int d, int h, int m, int s);
    return (32'(d) << 17) | (32'(h) << 12) | (32'(m) << 6) | 32'(s);
  endfunction

  // {start time, seconds stepped after the load tick, expected time}
  localparam logic [71:0] VEC [6] = '{
    {pk(0, 0, 0, 0),      8'd5, pk(0, 0, 0, 5)},
    {pk(0, 0, 0, 58),     8'd3, pk(0, 0, 1, 1)},
    {pk(0, 0, 59, 59),    8'd1, pk(0, 1, 0, 0)},
    {pk(7, 23, 59, 58),   8'd2, pk(8, 0, 0, 0)},
    {pk(32767, 23, 59, 59), 8'd1, pk(0, 0, 0, 0)},
    {pk(3, 12, 30, 0),    8'd0, pk(3, 12, 30, 0)}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic enables(int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      tick32k = 1'b1;
    end
    @(negedge clk);
    tick32k = 1'b0;
  endtask

  task automatic secs(int n);
    enables(n * PS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state, R11
    rd(A_TIME, v); check("R11 reset time", v, 0);
    rd(A_STAT, v); check("R11 reset status", v, 0);
    rd(A_MASK, v); check("R11 reset mask", v, 0);
    rd(A_SW, v);   check("R11 reset countdown", v, 0);
    check("R10 reset irq", {31'd0, irq}, 0);
    check("R10 reset wake", {31'd0, wake}, 0);

    // R1/R4: partial second, then a write restarts the prescaler
    enables(2);
    wr(A_TIME, pk(1, 2, 3, 4));
    repeat (3) @(negedge clk);
    enables(PS - 1);
    rd(A_TIME, v); check("R4 write deferred, R1 restart", v, 0);
    enables(1);
    rd(A_TIME, v); check("R4 load on tick, R1 count", v, pk(1, 2, 3, 4));

    // R2/R3 vector walk
    for (int i = 0; i < 6; i++) begin
      wr(A_TIME, VEC[i][71:40]);
      secs(1);
      secs(int'(VEC[i][39:32]));
      rd(A_TIME, v);
      check(i == 4 ? "R3 day wrap" : (i == 3 ? "R3 day advance" : "R2 rollover"), v, VEC[i][31:0]);
    end

    // R8/R9: status while masked
    wr(A_MASK, 0);
    wr(A_TIME, pk(0, 5, 0, 0));
    secs(1);
    wr(A_STAT, 32'h7F);
    secs(1);
    rd(A_STAT, v); check("R8 second bit", v & 32'hF, 1);
    check("R10 masked irq", {31'd0, irq}, 0);
    check("R10 masked wake", {31'd0, wake}, 0);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); check("R9 partial clear keeps bit", v & 32'h1, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, v); check("R9 write-1 clear", v & 32'h1, 0);

    // R10: enabled event
    wr(A_MASK, 32'h1);
    secs(1);
    check("R10 wake pulse", {31'd0, wake}, 1);
    check("R10 irq level", {31'd0, irq}, 1);
    @(negedge clk);
    check("R10 wake one cycle", {31'd0, wake}, 0);
    check("R10 irq held", {31'd0, irq}, 1);
    wr(A_STAT, 32'h1);
    check("R10 irq cleared", {31'd0, irq}, 0);
    wr(A_MASK, 0);

    // R8: rollover events
    wr(A_TIME, pk(9, 23, 59, 59));
    secs(1);
    rd(A_STAT, v); check("R8 load tick only bit0", v & 32'hF, 1);
    wr(A_STAT, 32'h7F);
    secs(1);
    rd(A_STAT, v); check("R8 day rollover bits", v & 32'hF, 32'hF);
    wr(A_TIME, pk(9, 1, 2, 59));
    secs(1);
    wr(A_STAT, 32'h7F);
    secs(1);
    rd(A_STAT, v); check("R8 minute rollover bits", v & 32'hF, 32'h3);

    // R5/R6 alarms
    wr(A_AL1, pk(3, 6, 7, 8));
    rd(A_AL1, v); check("R5 alarm A drops day", v, pk(0, 6, 7, 8));
    wr(A_AL2, pk(4, 6, 7, 8));
    rd(A_AL2, v); check("R6 alarm B readback", v, pk(4, 6, 7, 8));
    wr(A_TIME, pk(2, 6, 7, 6));
    secs(1);
    wr(A_STAT, 32'h7F);
    secs(1);
    rd(A_STAT, v); check("R5 no early match", v & 32'h30, 0);
    secs(1);
    rd(A_STAT, v); check("R5 match other day, R6 day mismatch", v & 32'h30, 32'h10);
    wr(A_TIME, pk(4, 6, 7, 7));
    secs(1);
    wr(A_STAT, 32'h7F);
    secs(1);
    rd(A_STAT, v); check("R6 full match", v & 32'h30, 32'h30);

    // R7 countdown
    wr(A_MASK, 32'h40);
    wr(A_STAT, 32'h7F);
    wr(A_SW, 3);
    rd(A_SW, v); check("R7 load", v, 3);
    secs(1);
    rd(A_SW, v); check("R7 step", v, 2);
    secs(2);
    rd(A_SW, v); check("R7 reach zero", v, 0);
    rd(A_STAT, v); check("R7 no event at zero", v & 32'h40, 0);
    secs(1);
    check("R7 underflow wake", {31'd0, wake}, 1);
    rd(A_STAT, v); check("R7 underflow event", v & 32'h40, 32'h40);
    rd(A_SW, v); check("R7 no wrap", v, 0);
    wr(A_STAT, 32'h7F);
    secs(2);
    rd(A_STAT, v); check("R7 single event", v & 32'h40, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule